// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Sequencer

This block drives one acquisition pass per channel number. A host loads channel numbers into an external command FIFO. The sequencer stays idle until that FIFO reports full. It then pulls one channel number and steers two external analog multiplexers to that channel. The first multiplexer is a 16-way single-ended switch. The second is an 8-way differential switch.

Four conversions are started on the serial 16-bit ADC. For each one the block waits for the ADC's busy flag to drop, then clocks the serial result in. The four results are summed, and the truncated mean is pushed into an external result FIFO for the host to read. Around the core sit the FIFOs, the multiplexers and the converter. The block sees only their flags, strobes and data lines.

Top module: `acq_sequencer`

## Requirements
- R1: The block leaves idle only while `cmd_full_i` is high. It then pulses `cmd_rd_o` high for exactly one cycle per channel, and never while the command FIFO is not full. `cmd_data_i` is sampled in the cycle after that pulse.
- R2: Channel numbers 0 to 7 drive `se_en_o`=1 and `diff_en_o`=0, with `se_addr_o` equal to the channel number.
- R3: Channel numbers 8 to 15 drive `diff_en_o`=1 and `se_en_o`=0, with `diff_addr_o` equal to the channel number minus 8.
- R4: The multiplexer enables and address lines hold their final values for at least one full cycle before `adc_rc_no` falls. They stay unchanged while it is low.
- R5: `adc_rc_no` is high except during a convert pulse. Each pulse is low for exactly 6 clock cycles.
- R6: After a convert pulse, `adc_sclk_o` stays low until `adc_busy_i` is seen low. Exactly 16 rising edges of `adc_sclk_o` are then produced for each conversion, with no rising edge while busy is high.
- R7: Serial bits are taken on the rising edge of `adc_sclk_o`, most significant bit first, to form a 16-bit sample.
- R8: Each channel number yields exactly four conversions and then one result write.
- R9: The written result equals floor(sum of the four samples / 4). The sum is kept without loss, so four samples of 0xFFFF give 0xFFFF.
- R10: The sum is cleared for every new channel, so a result never contains samples from an earlier channel.
- R11: `res_wr_o` is a single-cycle pulse. It is never issued while `res_full_i` is high. While the result FIFO is full, the block waits with no new conversion until space appears.
- R12: Out of reset, and between channels, both multiplexer enables are low, `adc_rc_no` is high, and `adc_sclk_o`, `cmd_rd_o` and `res_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 100 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_full_i | input | 1 | Command FIFO full flag |
| cmd_rd_o | output | 1 | Command FIFO read request |
| cmd_data_i | input | 4 | Channel number from command FIFO |
| se_addr_o | output | 4 | Single-ended multiplexer address |
| se_en_o | output | 1 | Single-ended multiplexer enable |
| diff_addr_o | output | 3 | Differential multiplexer address |
| diff_en_o | output | 1 | Differential multiplexer enable |
| adc_rc_no | output | 1 | ADC read/convert line, low starts a conversion |
| adc_busy_i | input | 1 | ADC busy flag, high while converting |
| adc_sclk_o | output | 1 | Serial data clock to the ADC |
| adc_sdata_i | input | 1 | Serial data from the ADC |
| res_full_i | input | 1 | Result FIFO full flag |
| res_wr_o | output | 1 | Result FIFO write strobe |
| res_data_o | output | 16 | Averaged result word |

## Verification
The hardest state to reach is a finished average held back by a full result FIFO. To get there, the bench raises the full flag just before a command FIFO fill triggers a channel. It then waits well past the length of four conversions and confirms that no write has appeared and that no further convert pulse has started, before it frees space. A second hard case is a partly filled command FIFO left alone for a long stretch, which must not start any activity. The ADC model in the bench works out which channel was selected from the multiplexer lines alone. Any decoding, ordering or sample-count error therefore shows up as a wrong average.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_READ,
    S_DECODE,
    S_SETTLE,
    S_CONV,
    S_WAIT,
    S_SHIFT,
    S_ACCUM,
    S_STORE
  } seq_state_e;
endpackage

// File: rtl/acq_chan_decode.sv
module acq_chan_decode #(
  parameter int CH_W        = 4,
  parameter int SE_ADDR_W   = 4,
  parameter int DIFF_ADDR_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   clear_i,
  input  logic [CH_W-1:0]        chan_i,
  output logic [SE_ADDR_W-1:0]   se_addr_o,
  output logic                   se_en_o,
  output logic [DIFF_ADDR_W-1:0] diff_addr_o,
  output logic                   diff_en_o
);
  localparam int SPLIT = 1 << DIFF_ADDR_W;

  logic to_diff;
  assign to_diff = (32'(chan_i) >= SPLIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se_addr_o   <= '0;
      se_en_o     <= 1'b0;
      diff_addr_o <= '0;
      diff_en_o   <= 1'b0;
    end else if (clear_i) begin
      se_addr_o   <= '0;
      se_en_o     <= 1'b0;
      diff_addr_o <= '0;
      diff_en_o   <= 1'b0;
    end else if (load_i) begin
      se_en_o     <= !to_diff;
      diff_en_o   <= to_diff;
      se_addr_o   <= to_diff ? '0 : SE_ADDR_W'(chan_i);
      diff_addr_o <= chan_i[DIFF_ADDR_W-1:0];
    end
  end

  // R2 R3
  exclusive_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(se_en_o && diff_en_o));
endmodule

// File: rtl/acq_serial_rx.sv
module acq_serial_rx #(
  parameter int DW  = 16,
  parameter int DIV = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sdata_i,
  output logic          sclk_o,
  output logic [DW-1:0] word_o,
  output logic          done_o
);
  localparam int DIV_W  = $clog2(DIV + 1);
  localparam int BITS_W = $clog2(DW + 1);

  logic              active_q;
  logic [DIV_W-1:0]  div_q;
  logic [BITS_W-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bits_q   <= '0;
      sclk_o   <= 1'b0;
      word_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          div_q    <= '0;
          bits_q   <= '0;
          sclk_o   <= 1'b0;
        end
      end else if (div_q == DIV_W'(DIV - 1)) begin
        div_q <= '0;
        if (!sclk_o) begin
          // rising edge: take next bit, MSB first
          sclk_o <= 1'b1;
          word_o <= {word_o[DW-2:0], sdata_i};
          bits_q <= bits_q + 1'b1;
        end else begin
          sclk_o <= 1'b0;
          if (bits_q == BITS_W'(DW)) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R6
  idle_sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_o);
endmodule

// File: rtl/acq_avg_accum.sv
module acq_avg_accum #(
  parameter int SAMPLE_W = 16,
  parameter int AVG_LOG2 = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                last_o,
  output logic [SAMPLE_W-1:0] avg_o
);
  localparam int ACC_W = SAMPLE_W + AVG_LOG2;
  localparam int N_AVG = 1 << AVG_LOG2;

  logic [ACC_W-1:0]    acc_q;
  logic [AVG_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (add_i) begin
      acc_q <= acc_q + ACC_W'(sample_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == AVG_LOG2'(N_AVG - 1));
  assign avg_o  = acc_q[ACC_W-1:AVG_LOG2];

  // R9
  acc_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int CH_W         = 4,
  parameter int SE_ADDR_W    = 4,
  parameter int DIFF_ADDR_W  = 3,
  parameter int SAMPLE_W     = 16,
  parameter int AVG_LOG2     = 2,
  parameter int CONV_LOW_CYC = 6,
  parameter int SETTLE_CYC   = 1,
  parameter int SCLK_DIV     = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_full_i,
  output logic                   cmd_rd_o,
  input  logic [CH_W-1:0]        cmd_data_i,
  output logic [SE_ADDR_W-1:0]   se_addr_o,
  output logic                   se_en_o,
  output logic [DIFF_ADDR_W-1:0] diff_addr_o,
  output logic                   diff_en_o,
  output logic                   adc_rc_no,
  input  logic                   adc_busy_i,
  output logic                   adc_sclk_o,
  input  logic                   adc_sdata_i,
  input  logic                   res_full_i,
  output logic                   res_wr_o,
  output logic [SAMPLE_W-1:0]    res_data_o
);
  localparam int TMR_MAX = (CONV_LOW_CYC > SETTLE_CYC) ? CONV_LOW_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_e state_q, state_d;
  logic [TMR_W-1:0]    tmr_q;
  logic                rx_start, rx_done, acc_last;
  logic [SAMPLE_W-1:0] rx_word, avg;
  logic                store_go;

  assign store_go = (state_q == S_STORE) && !res_full_i;
  assign rx_start = (state_q == S_WAIT) && !adc_busy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (cmd_full_i) state_d = S_READ;
      S_READ:   state_d = S_DECODE;
      S_DECODE: state_d = S_SETTLE;
      S_SETTLE: if (tmr_q == TMR_W'(SETTLE_CYC - 1)) state_d = S_CONV;
      S_CONV:   if (tmr_q == TMR_W'(CONV_LOW_CYC - 1)) state_d = S_WAIT;
      S_WAIT:   if (!adc_busy_i) state_d = S_SHIFT;
      S_SHIFT:  if (rx_done) state_d = S_ACCUM;
      S_ACCUM:  state_d = acc_last ? S_STORE : S_CONV;
      S_STORE:  if (!res_full_i) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      tmr_q      <= '0;
      res_wr_o   <= 1'b0;
      res_data_o <= '0;
    end else begin
      state_q  <= state_d;
      tmr_q    <= (state_d != state_q) ? '0 : tmr_q + 1'b1;
      res_wr_o <= store_go;
      if (store_go) res_data_o <= avg;
    end
  end

  assign cmd_rd_o  = (state_q == S_READ);
  assign adc_rc_no = (state_q != S_CONV);

  acq_chan_decode #(
    .CH_W       (CH_W),
    .SE_ADDR_W  (SE_ADDR_W),
    .DIFF_ADDR_W(DIFF_ADDR_W)
  ) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_q == S_DECODE),
    .clear_i    (store_go),
    .chan_i     (cmd_data_i),
    .se_addr_o  (se_addr_o),
    .se_en_o    (se_en_o),
    .diff_addr_o(diff_addr_o),
    .diff_en_o  (diff_en_o)
  );

  acq_serial_rx #(
    .DW (SAMPLE_W),
    .DIV(SCLK_DIV)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rx_start),
    .sdata_i(adc_sdata_i),
    .sclk_o (adc_sclk_o),
    .word_o (rx_word),
    .done_o (rx_done)
  );

  acq_avg_accum #(
    .SAMPLE_W(SAMPLE_W),
    .AVG_LOG2(AVG_LOG2)
  ) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == S_DECODE),
    .add_i   (state_q == S_ACCUM),
    .sample_i(rx_word),
    .last_o  (acc_last),
    .avg_o   (avg)
  );

  // R1
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rd_o |=> !cmd_rd_o);

  // R4
  mux_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rc_no) |-> $stable(se_en_o) && $stable(diff_en_o) &&
      $stable(se_addr_o) && $stable(diff_addr_o) && (se_en_o || diff_en_o));

  // R5
  conv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rc_no) |=> !adc_rc_no);

  // R6
  sclk_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_sclk_o) |-> !adc_busy_i);

  // R11
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_wr_o |=> !res_wr_o);
endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int CONV_LOW   = 6;
  localparam int BUSY_CYC   = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_full, cmd_rd;
  logic [3:0] cmd_dout;
  logic [3:0] se_addr;
  logic se_en;
  logic [2:0] diff_addr;
  logic diff_en, rc_n, busy, sclk, sdata, res_full, res_wr;
  logic [15:0] res_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acq_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_full_i(cmd_full), .cmd_rd_o(cmd_rd),
    .cmd_data_i(cmd_dout), .se_addr_o(se_addr), .se_en_o(se_en),
    .diff_addr_o(diff_addr), .diff_en_o(diff_en), .adc_rc_no(rc_n),
    .adc_busy_i(busy), .adc_sclk_o(sclk), .adc_sdata_i(sdata),
    .res_full_i(res_full), .res_wr_o(res_wr), .res_data_o(res_data)
  );

  int tests = 0, fails = 0;
  int cmd_q[$], exp_q[$], exp_ch_q[$];
  int cur_ch = 0, conv_in_ch = 0, conv_n = 0, rises = 0, rc_low = 0, busy_cnt = 0;
  int rd_count = 0, wr_count = 0, fall_count = 0;
  bit in_flight = 0, finished = 0;
  logic [15:0] adc_word = '0;
  logic rc_prev = 1'b1, sclk_prev = 1'b0, p_se_en = 1'b0, p_diff_en = 1'b0;
  logic [3:0] p_se_addr = '0;
  logic [2:0] p_diff_addr = '0;

  function automatic logic [15:0] samp(int ch, int k);
    if (ch == 15) return 16'hFFFF;
    if (ch == 9) return 16'((k == 3) ? 3 : k + 1);
    return 16'((ch * 4369) ^ (k * 855 + 3 * k));
  endfunction

  function automatic int exp_avg(int ch);
    int s = 0;
    for (int k = 0; k < 4; k++) s += int'(samp(ch, k));
    return s / 4;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Behavioural model of the command FIFO, ADC and result FIFO, checked every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_rd) begin
        chk(cmd_q.size() == DEPTH, "R1", "read while not full", cmd_q.size(), DEPTH);
        if (cmd_q.size() > 0) cmd_dout = 4'(cmd_q.pop_front());
        cur_ch = int'(cmd_dout); conv_in_ch = 0; in_flight = 1; rd_count++;
        cmd_full = (cmd_q.size() == DEPTH);
      end
      if (!in_flight)
        chk(!se_en && !diff_en && rc_n && !sclk, "R12", "idle outputs",
            {se_en, diff_en, rc_n, sclk}, 4'b0010);
      if (busy) begin
        busy_cnt--;
        if (busy_cnt == 0) begin busy = 1'b0; sdata = adc_word[15]; end
      end
      if (rc_prev && !rc_n) begin
        int ch_seen;
        fall_count++; conv_in_ch++;
        if (conv_n > 0) chk(rises == 16, "R6", "sclk rises per conversion", rises, 16);
        rises = 0;
        if (cur_ch < 8)
          chk(se_en && !diff_en && int'(se_addr) == cur_ch, "R2", "single-ended decode",
              {se_en, diff_en, se_addr}, {2'b10, 4'(cur_ch)});
        else
          chk(!se_en && diff_en && int'(diff_addr) == cur_ch - 8, "R3", "differential decode",
              {se_en, diff_en, diff_addr}, {2'b01, 3'(cur_ch - 8)});
        chk(se_en == p_se_en && diff_en == p_diff_en &&
            (se_en ? se_addr == p_se_addr : diff_addr == p_diff_addr),
            "R4", "mux lines set before convert", {se_en, diff_en}, {p_se_en, p_diff_en});
        ch_seen = se_en ? int'(se_addr) : 8 + int'(diff_addr);
        adc_word = samp(ch_seen, conv_n % 4);
        conv_n++;
        busy = 1'b1; busy_cnt = BUSY_CYC; rc_low = 0;
      end
      if (!rc_n) begin
        rc_low++;
        if (!rc_prev) chk(se_en == p_se_en && diff_en == p_diff_en, "R4",
                          "mux held during convert", {se_en, diff_en}, {p_se_en, p_diff_en});
      end
      if (rc_n && !rc_prev) chk(rc_low == CONV_LOW, "R5", "convert pulse width", rc_low, CONV_LOW);
      if (!sclk_prev && sclk) begin
        rises++;
        chk(!busy, "R6", "sclk rise while busy", 1, 0);
      end
      if (sclk_prev && !sclk) begin
        adc_word = adc_word << 1;
        sdata = adc_word[15];
      end
      if (res_wr) begin
        int e, ech;
        string req;
        chk(!res_full, "R11", "write while full", 1, 0);
        chk(conv_in_ch == 4, "R8", "conversions per channel", conv_in_ch, 4);
        chk(rises == 16, "R6", "sclk rises last conversion", rises, 16);
        e = 0; ech = -1;
        if (exp_q.size() > 0) begin e = exp_q.pop_front(); ech = exp_ch_q.pop_front(); end
        req = (ech == 12) ? "R7" : (ech == 5) ? "R10" : "R9";
        chk(int'(res_data) == e, req, "average", int'(res_data), e);
        wr_count++; in_flight = 0;
      end
      rc_prev = rc_n; sclk_prev = sclk;
      p_se_en = se_en; p_diff_en = diff_en; p_se_addr = se_addr; p_diff_addr = diff_addr;
    end
  end

  task automatic push_ch(int ch);
    do begin @(negedge clk); #1; end while (cmd_q.size() >= DEPTH);
    cmd_q.push_back(ch);
    exp_q.push_back(exp_avg(ch));
    exp_ch_q.push_back(ch);
    cmd_full = (cmd_q.size() == DEPTH);
  endtask

  task automatic wait_writes(int n);
    int guard = 0;
    while (wr_count < n && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    int list[12] = '{0, 3, 7, 8, 9, 12, 15, 5, 2, 11, 6, 1};
    int wr_snap, fall_snap;
    rst_n = 1'b0; cmd_full = 1'b0; cmd_dout = '0; busy = 1'b0; sdata = 1'b0; res_full = 1'b0;
    repeat (3) @(negedge clk);
    chk(!se_en && !diff_en, "R12", "enables after reset", {se_en, diff_en}, 0);
    chk(rc_n && !sclk, "R12", "adc lines after reset", {rc_n, sclk}, 2'b10);
    chk(!cmd_rd && !res_wr, "R12", "strobes after reset", {cmd_rd, res_wr}, 0);
    #1 rst_n = 1'b1;

    // partly filled command FIFO must not start anything
    for (int i = 0; i < 3; i++) push_ch(list[i]);
    repeat (150) @(negedge clk);
    chk(rd_count == 0, "R1", "no read before full", rd_count, 0);
    chk(fall_count == 0, "R1", "no convert before full", fall_count, 0);

    for (int i = 3; i < 6; i++) push_ch(list[i]);
    wait_writes(3);
    chk(wr_count == 3, "R8", "results after three fills", wr_count, 3);

    // stall on full result FIFO
    @(negedge clk); #1 res_full = 1'b1;
    push_ch(list[6]);
    repeat (1000) @(negedge clk);
    wr_snap = wr_count; fall_snap = fall_count;
    repeat (500) @(negedge clk);
    chk(wr_count == 3, "R11", "no write while full", wr_count, 3);
    chk(fall_count == fall_snap && wr_count == wr_snap, "R11", "stalled in store",
        fall_count, fall_snap);
    #1 res_full = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_count == 4, "R11", "write after space", wr_count, 4);

    for (int i = 7; i < 12; i++) push_ch(list[i]);
    wait_writes(9);
    repeat (50) @(negedge clk);
    chk(wr_count == 9, "R8", "total results", wr_count, 9);
    chk(exp_q.size() == 3, "R1", "entries left unread", exp_q.size(), 3);
    chk(!in_flight && rc_n, "R12", "quiet at end", {in_flight, rc_n}, 2'b01);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule